// File: doc/BRIEF.md
# Dual-Port GPIO Register Bank

This block keeps the register state of a sixteen-pin general-purpose I/O expander, arranged as two ports of eight pins each. A bus front end, outside this block, turns serial transactions into single-cycle register accesses. It presents a register index, a write strobe with write data, or a read strobe. The bank answers each read one cycle later. The bank holds four registers per port:

- a sampled copy of the pin levels;
- the output levels;
- a per-bit inversion mask applied when the sampled levels are read;
- a direction mask.

On the pin side the block takes the raw input levels and produces a level and an enable for every pin. A build parameter picks push-pull drive or open-drain drive. Open-drain drive never pulls a pin high and leaves the high level to an external pull-up. A synchronous reset stands in for the power-on reset and brings every register back to its default value.

Read data is a simple one-way stream. `rd_valid` marks the single cycle in which `rd_data` holds the answer to a read. There is no back-pressure: the front end must take the value in that cycle. Writes are fire-and-forget and always complete in the cycle they are issued.

Top module: `gpio_regbank`

## Requirements
- R1: Index bits [2:1] select the register kind: 0 is sampled input, 1 is output level, 2 is inversion mask and 3 is direction. Index bit 0 selects the port. Bit i of port p maps to pin p*8+i.
- R2: A read strobe in one cycle makes `rd_valid` high in the next cycle, with the answer on `rd_data`. `rd_valid` is low in every cycle that follows a cycle without a read strobe.
- R3: Reading index 0 or 1 returns the port's pin levels, sampled one clock earlier, XOR its inversion mask. A mask bit of 1 inverts that bit and a mask bit of 0 passes it unchanged.
- R4: After reset, both output registers are 0xFF, both inversion masks are 0x00, and both direction registers are 0xFF, so every `pin_oe` bit is 0.
- R5: A direction bit of 1 makes the pin an input, with its `pin_oe` bit at 0. A direction bit of 0 makes it an output.
- R6: With OPEN_DRAIN=0, `pin_out` equals the output register bits and `pin_oe` is the inverse of the direction bits.
- R7: With OPEN_DRAIN=1, `pin_out` is always 0. A pin is enabled only when it is an output and its output bit is 0.
- R8: Writes to index 0 or 1 have no effect. The sampled input keeps following the pins, including pins set as outputs.
- R9: The output, inversion and direction registers read back the last value written to them.
- R10: Indices 8 to 15 read as 0x00, and writes to them change no register.
- R11: A write takes effect at the clock edge where it is strobed, and the pins show the new value right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_idx | input | 4 | Register index for the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read answer, valid while rd_valid is high |
| rd_valid | output | 1 | Marks the cycle carrying a read answer |
| pin_in | input | 16 | Raw pin levels |
| pin_out | output | 16 | Level driven onto each pin |
| pin_oe | output | 16 | Drive enable for each pin |

## Verification
The input readback is swept over all 256 inversion masks for port 0, with the complementary mask on port 1, while the pin pattern changes every step. This separates inverted bits from passed bits and port 0 from port 1. A second sweep walks 256 combinations of output level and direction on both ports. It checks a push-pull instance and an open-drain instance side by side, which tells the high-side drive apart from the released state. Writes to the read-only indices and to indices 8 to 15 are each followed by readback and pin checks, which show whether anything changed.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
  localparam int unsigned NUM_PORTS = 2;

  typedef enum logic [1:0] {
    FN_INPUT  = 2'd0,
    FN_OUTPUT = 2'd1,
    FN_POLAR  = 2'd2,
    FN_DIR    = 2'd3
  } reg_fn_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned PORT_W     = 8,
  parameter bit          OPEN_DRAIN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_out,
  input  logic              wr_pol,
  input  logic              wr_dir,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] out_q,
  output logic [PORT_W-1:0] pol_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] in_view,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe
);
  localparam logic [PORT_W-1:0] ONES  = {PORT_W{1'b1}};
  localparam logic [PORT_W-1:0] ZEROS = {PORT_W{1'b0}};

  logic [PORT_W-1:0] in_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= ONES;
      pol_q <= ZEROS;
      dir_q <= ONES;
      in_q  <= ZEROS;
    end else begin
      in_q <= pin_in;
      if (wr_out) out_q <= wr_data;
      if (wr_pol) pol_q <= wr_data;
      if (wr_dir) dir_q <= wr_data;
    end
  end

  assign in_view = in_q ^ pol_q;

  generate
    if (OPEN_DRAIN) begin : g_od
      assign pad_out = ZEROS;
      assign pad_oe  = ~dir_q & ~out_q;
    end else begin : g_pp
      assign pad_out = out_q;
      assign pad_oe  = ~dir_q;
    end
  endgenerate

  assert_reset_defaults_R4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_q == ONES && pol_q == ZEROS && dir_q == ONES));
  assert_input_tracks_pins_R8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> in_q == $past(pin_in));
  assert_out_write_R9: assert property (@(posedge clk) disable iff (rst)
    wr_out |=> out_q == $past(wr_data));
  assert_pol_write_R9: assert property (@(posedge clk) disable iff (rst)
    wr_pol |=> pol_q == $past(wr_data));
  assert_dir_write_R9: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> dir_q == $past(wr_data));
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic [NUM_PORTS-1:0][PORT_W-1:0] in_view,
  input  logic [NUM_PORTS-1:0][PORT_W-1:0] out_q,
  input  logic [NUM_PORTS-1:0][PORT_W-1:0] pol_q,
  input  logic [NUM_PORTS-1:0][PORT_W-1:0] dir_q,
  input  reg_fn_e                          fn,
  input  logic                             port,
  input  logic                             in_range,
  output logic [PORT_W-1:0]                data
);
  always_comb begin
    data = '0;
    if (in_range) begin
      unique case (fn)
        FN_INPUT:  data = in_view[port];
        FN_OUTPUT: data = out_q[port];
        FN_POLAR:  data = pol_q[port];
        FN_DIR:    data = dir_q[port];
        default:   data = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned PORT_W     = 8,
  parameter int unsigned IDX_W      = 4,
  parameter bit          OPEN_DRAIN = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [IDX_W-1:0]              reg_idx,
  input  logic                          wr_en,
  input  logic [PORT_W-1:0]             wr_data,
  input  logic                          rd_en,
  output logic [PORT_W-1:0]             rd_data,
  output logic                          rd_valid,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_out,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_oe
);
  localparam int unsigned PINS = NUM_PORTS * PORT_W;

  reg_fn_e fn;
  logic    port;
  logic    in_range;
  logic    wr_hit;

  assign fn       = reg_fn_e'(reg_idx[2:1]);
  assign port     = reg_idx[0];
  assign in_range = (reg_idx[IDX_W-1:3] == '0);
  assign wr_hit   = wr_en && in_range;

  logic [NUM_PORTS-1:0][PORT_W-1:0] in_view, out_q, pol_q, dir_q;
  logic [PINS-1:0]                  dir_flat;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic sel;
      assign sel = (port == p[0]);
      gpio_port_regs #(.PORT_W(PORT_W), .OPEN_DRAIN(OPEN_DRAIN)) port_i (
        .clk     (clk),
        .rst     (rst),
        .wr_out  (wr_hit && sel && fn == FN_OUTPUT),
        .wr_pol  (wr_hit && sel && fn == FN_POLAR),
        .wr_dir  (wr_hit && sel && fn == FN_DIR),
        .wr_data (wr_data),
        .pin_in  (pin_in[p*PORT_W +: PORT_W]),
        .out_q   (out_q[p]),
        .pol_q   (pol_q[p]),
        .dir_q   (dir_q[p]),
        .in_view (in_view[p]),
        .pad_out (pin_out[p*PORT_W +: PORT_W]),
        .pad_oe  (pin_oe[p*PORT_W +: PORT_W])
      );
      assign dir_flat[p*PORT_W +: PORT_W] = dir_q[p];
    end
  endgenerate

  logic [PORT_W-1:0] rd_next;

  gpio_read_mux #(.PORT_W(PORT_W)) mux_i (
    .in_view  (in_view),
    .out_q    (out_q),
    .pol_q    (pol_q),
    .dir_q    (dir_q),
    .fn       (fn),
    .port     (port),
    .in_range (in_range),
    .data     (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  assert_read_valid_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  assert_oob_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_idx[IDX_W-1:3] != '0) |=> rd_data == '0);
  assert_input_hiz_R5: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & dir_flat) == '0);
endmodule

// File: tb/gpio_regbank_tb.sv
module gpio_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_idx = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [15:0] pin_in = '0;
  logic [7:0]  rd_data, od_rd_data;
  logic        rd_valid, od_rd_valid;
  logic [15:0] pin_out, pin_oe, od_pin_out, od_pin_oe;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gpio_regbank #(.OPEN_DRAIN(1'b0)) dut_i (
    .clk(clk), .rst(rst), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  gpio_regbank #(.OPEN_DRAIN(1'b1)) dut_od_i (
    .clk(clk), .rst(rst), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(od_rd_data), .rd_valid(od_rd_valid),
    .pin_in(pin_in), .pin_out(od_pin_out), .pin_oe(od_pin_oe));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk);
    reg_idx = i; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] i, input logic [7:0] exp);
    @(negedge clk);
    reg_idx = i; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, {8'h00, rd_data}, {8'h00, exp});
    chk({req, " od"}, {8'h00, od_rd_data}, {8'h00, exp});
    chk("R2 valid", {15'h0, rd_valid & od_rd_valid}, 16'h1);
  endtask

  // expected pins for both drive styles from output regs and direction regs
  task automatic pins_chk(input logic [15:0] o, input logic [15:0] d);
    chk("R6 pp pin_out", pin_out, o);
    chk("R5 R6 pp pin_oe", pin_oe, ~d);
    chk("R7 od pin_out", od_pin_out, 16'h0000);
    chk("R7 od pin_oe", od_pin_oe, ~d & ~o);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    logic [7:0] o0, o1, d0, d1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R4 reset state
    pins_chk(16'hFFFF, 16'hFFFF);
    chk("R2 idle valid", {15'h0, rd_valid}, 16'h0);
    rd_chk("R4 out0", 4'd2, 8'hFF);
    rd_chk("R4 out1", 4'd3, 8'hFF);
    rd_chk("R4 pol0", 4'd4, 8'h00);
    rd_chk("R4 pol1", 4'd5, 8'h00);
    rd_chk("R4 dir0", 4'd6, 8'hFF);
    rd_chk("R4 dir1", 4'd7, 8'hFF);
    rd_chk("R3 in0 reset", 4'd0, 8'h00);

    // R3 R1: inversion sweep
    for (int p = 0; p < 256; p++) begin
      logic [7:0] a, b;
      wr(4'd4, p[7:0]);
      wr(4'd5, ~p[7:0]);
      chk("R2 no read no valid", {15'h0, rd_valid}, 16'h0);
      a = p[7:0] * 8'd5 + 8'd1;
      b = p[7:0] ^ 8'h3C;
      pin_in = {b, a};
      rd_chk("R3 in0", 4'd0, a ^ p[7:0]);
      rd_chk("R3 R1 in1", 4'd1, b ^ ~p[7:0]);
    end

    // R5 R6 R7 R9 R11: output level and direction sweep
    for (int v = 0; v < 256; v++) begin
      o0 = v[7:0];
      o1 = v[7:0] * 8'd3 ^ 8'hA5;
      d0 = v[7:0] ^ 8'h0F;
      d1 = {v[3:0], v[7:4]};
      wr(4'd2, o0);
      wr(4'd3, o1);
      wr(4'd6, d0);
      wr(4'd7, d1);
      pins_chk({o1, o0}, {d1, d0});
      if (v[3:0] == 4'd0) begin
        rd_chk("R9 out0", 4'd2, o0);
        rd_chk("R9 out1", 4'd3, o1);
        rd_chk("R9 dir0", 4'd6, d0);
        rd_chk("R9 dir1", 4'd7, d1);
      end
    end

    // R11: pins follow right after the write edge
    wr(4'd6, 8'h00);
    pins_chk({o1, o0}, {d1, 8'h00});
    wr(4'd7, 8'h00);
    pins_chk({o1, o0}, 16'h0000);

    // R8: input indices ignore writes, input follows output pins
    wr(4'd4, 8'h00);
    wr(4'd5, 8'h00);
    pin_in = 16'h1234;
    wr(4'd0, 8'hFF);
    wr(4'd1, 8'hFF);
    rd_chk("R8 in0 after write", 4'd0, 8'h34);
    rd_chk("R8 in1 after write", 4'd1, 8'h12);
    rd_chk("R8 pol0 untouched", 4'd4, 8'h00);
    rd_chk("R8 out0 untouched", 4'd2, o0);

    // R10: indices 8..15
    wr(4'd4, 8'h5A);
    wr(4'd7, 8'h81);
    for (int i = 8; i < 16; i++) begin
      wr(i[3:0], 8'h00);
      rd_chk("R10 oob read", i[3:0], 8'h00);
    end
    rd_chk("R10 out0 kept", 4'd2, o0);
    rd_chk("R10 out1 kept", 4'd3, o1);
    rd_chk("R10 pol0 kept", 4'd4, 8'h5A);
    rd_chk("R10 pol1 kept", 4'd5, 8'h00);
    rd_chk("R10 dir0 kept", 4'd6, 8'h00);
    rd_chk("R10 dir1 kept", 4'd7, 8'h81);
    pins_chk({o1, o0}, 16'h8100);

    // R4: reset again restores defaults
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    pins_chk(16'hFFFF, 16'hFFFF);
    rd_chk("R4 pol0 after reset", 4'd4, 8'h00);
    rd_chk("R4 dir1 after reset", 4'd7, 8'hFF);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule